// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This block keeps wall-clock time as a 32-bit count of seconds. A prescaler divides the input clock by a parameter, `TICKS_PER_SEC`, to make a one-cycle tick once per second. On each tick the seconds counter either advances by one or takes a value that software staged earlier in a load register. A time write therefore becomes visible only at the next one-second boundary, and the count never moves faster than once per second.

An alarm compares each new counter value with a match register. When they are equal and alarms are enabled, a sticky raw flag is set. A separate mask bit decides whether that flag reaches the level interrupt output. Software clears the flag by reading a dedicated acknowledge register.

Access goes through a plain 32-bit register port with separate read and write strobes. Read data is registered and appears one cycle after the read strobe.

Top module: `sec_rtc`

## Requirements
- R1: After a synchronous reset, the counter, match, load and control registers are zero. `irq_out` is low and `bus_rdata` is zero.
- R2: While control bit 2 (run) is 1, the counter at word 0 advances by exactly one every `TICKS_PER_SEC` clock cycles.
- R3: While the run bit is 0, both the prescaler and the counter hold their values. When counting resumes, the prescaler continues from the phase it held.
- R4: A write to word 2 (load) leaves the counter unchanged until the next tick. At that tick the counter takes the written value. Word 2 reads back the last value written.
- R5: At all-ones, a tick moves the counter to zero if control bit 3 (wrap) is 1, and leaves it at all-ones if the wrap bit is 0.
- R6: The raw flag (word 5 bit 0) is set on a tick whose new counter value equals the match register (word 1), but only while control bit 0 (alarm enable) is 1, whatever the mask.
- R7: Word 4 bit 0 and `irq_out` both equal the raw flag AND NOT control bit 1 (mask).
- R8: A read of word 6 returns the raw flag in bit 0 and then clears it. If a new alarm sets the flag in the same cycle, the set wins.
- R9: Word 7 returns `VERSION`. Writes to words 0, 4, 5, 6 and 7 are ignored. Reads of addresses beyond word 7 return zero.
- R10: The control register (word 3) keeps only bits 3:0 and reads zero above them. The match register reads back the value written.
- R11: `bus_rdata` changes only on a clock edge where `bus_rd` is high, one cycle after the read is presented, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the time base |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Level alarm interrupt |

## Verification
The assertions assume that the tick reaches the counter and alarm only from the prescaler, and that at most one access is presented per cycle. They also assume that reset is applied synchronously before any access. The bench drives every access from the falling edge and never asserts read and write together. It uses only word-aligned addresses inside the decoded window, plus a few just beyond it.

Random control writes keep the run bit set most of the time, so the seconds boundaries stay dense. Random match values are placed a few seconds ahead of the current count, so alarms and acknowledge reads collide in the same cycle often.

// File: rtl/sec_rtc_pkg.sv
`timescale 1ns/1ps
package sec_rtc_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    WI_COUNT = 3'd0,
    WI_MATCH = 3'd1,
    WI_LOAD  = 3'd2,
    WI_CTRL  = 3'd3,
    WI_STAT  = 3'd4,
    WI_RAW   = 3'd5,
    WI_EOI   = 3'd6,
    WI_VER   = 3'd7
  } word_idx_e;

  // bit3 wrap, bit2 run, bit1 mask, bit0 alarm enable
  typedef struct packed {
    logic wrap_en;
    logic run;
    logic irq_mask;
    logic irq_en;
  } ctrl_t;
endpackage

// File: rtl/sec_rtc_prescaler.sv
`timescale 1ns/1ps
module sec_rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  generate
    if (TICKS_PER_SEC <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_div
      localparam int PW = $clog2(TICKS_PER_SEC);
      localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);
      logic [PW-1:0] phase_q;

      assign tick = run && (phase_q == LAST);

      always_ff @(posedge clk) begin
        if (rst) begin
          phase_q <= '0;
        end else if (run) begin
          phase_q <= tick ? '0 : phase_q + PW'(1);
        end
      end

      assert_phase_range_R2: assert property (@(posedge clk) disable iff (rst)
        phase_q <= LAST);
      assert_phase_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(phase_q));
    end
  endgenerate
endmodule

// File: rtl/sec_rtc_counter.sv
`timescale 1ns/1ps
module sec_rtc_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wrap_en,
  input  logic         load_wr,
  input  logic [W-1:0] load_data,
  output logic [W-1:0] count_q,
  output logic [W-1:0] load_q,
  output logic [W-1:0] next_val
);
  localparam logic [W-1:0] ALL1 = {W{1'b1}};
  logic pend_q;

  always_comb begin
    if (pend_q)                next_val = load_q;
    else if (count_q == ALL1)  next_val = wrap_en ? '0 : ALL1;
    else                       next_val = count_q + W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      load_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (tick) count_q <= next_val;
      if (load_wr) begin
        load_q <= load_data;
        pend_q <= 1'b1;
      end else if (tick) begin
        pend_q <= 1'b0;
      end
    end
  end

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count_q));
  assert_load_apply_R4: assert property (@(posedge clk) disable iff (rst)
    tick && pend_q |=> count_q == $past(load_q));
  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    tick && !pend_q && count_q != ALL1 |=> count_q == $past(count_q) + W'(1));
  assert_saturate_R5: assert property (@(posedge clk) disable iff (rst)
    tick && !pend_q && count_q == ALL1 && !wrap_en |=> count_q == ALL1);
  assert_rollover_R5: assert property (@(posedge clk) disable iff (rst)
    tick && !pend_q && count_q == ALL1 && wrap_en |=> count_q == '0);
endmodule

// File: rtl/sec_rtc_alarm.sv
`timescale 1ns/1ps
module sec_rtc_alarm #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] next_val,
  input  logic         irq_en,
  input  logic         mask_nxt,
  input  logic         match_wr,
  input  logic [W-1:0] match_data,
  input  logic         eoi_rd,
  output logic [W-1:0] match_q,
  output logic         raw_q,
  output logic         irq_q
);
  logic set_ev;
  logic raw_d;

  assign set_ev = tick && irq_en && (next_val == match_q);

  always_comb begin
    if (set_ev)      raw_d = 1'b1;
    else if (eoi_rd) raw_d = 1'b0;
    else             raw_d = raw_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '0;
      raw_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (match_wr) match_q <= match_data;
      raw_q <= raw_d;
      irq_q <= raw_d & ~mask_nxt;
    end
  end

  assert_raw_needs_en_R6: assert property (@(posedge clk) disable iff (rst)
    !raw_q && !irq_en |=> !raw_q);
  assert_raw_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    raw_q && !eoi_rd |=> raw_q);
  assert_no_alarm_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !raw_q && !tick |=> !raw_q);
endmodule

// File: rtl/sec_rtc.sv
`timescale 1ns/1ps
module sec_rtc
  import sec_rtc_pkg::*;
#(
  parameter int          TICKS_PER_SEC = 32768,
  parameter int          ADDR_W        = 6,
  parameter logic [31:0] VERSION       = 32'h0001_0200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_out
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              hit;
  word_idx_e         idx;
  logic              unused_lsb;

  assign word       = bus_addr[ADDR_W-1:2];
  assign hit        = ((word >> 3) == '0);
  assign idx        = word_idx_e'(word[2:0]);
  assign unused_lsb = &{1'b0, bus_addr[1:0]};

  logic wr_ctrl, wr_match, wr_load, rd_eoi;
  assign wr_ctrl  = bus_wr && hit && (idx == WI_CTRL);
  assign wr_match = bus_wr && hit && (idx == WI_MATCH);
  assign wr_load  = bus_wr && hit && (idx == WI_LOAD);
  assign rd_eoi   = bus_rd && hit && (idx == WI_EOI);

  ctrl_t ctrl_q, ctrl_d;
  assign ctrl_d = wr_ctrl ? ctrl_t'(bus_wdata[3:0]) : ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_d;
  end

  logic              tick;
  logic [DATA_W-1:0] count_q, load_q, next_val, match_q;
  logic              raw_q, irq_q;

  sec_rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk (clk),
    .rst (rst),
    .run (ctrl_q.run),
    .tick(tick)
  );

  sec_rtc_counter #(.W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .wrap_en  (ctrl_q.wrap_en),
    .load_wr  (wr_load),
    .load_data(bus_wdata),
    .count_q  (count_q),
    .load_q   (load_q),
    .next_val (next_val)
  );

  sec_rtc_alarm #(.W(DATA_W)) u_alm (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .next_val  (next_val),
    .irq_en    (ctrl_q.irq_en),
    .mask_nxt  (ctrl_d.irq_mask),
    .match_wr  (wr_match),
    .match_data(bus_wdata),
    .eoi_rd    (rd_eoi),
    .match_q   (match_q),
    .raw_q     (raw_q),
    .irq_q     (irq_q)
  );

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit) begin
      case (idx)
        WI_COUNT: rd_mux = count_q;
        WI_MATCH: rd_mux = match_q;
        WI_LOAD:  rd_mux = load_q;
        WI_CTRL:  rd_mux = {28'd0, ctrl_q};
        WI_STAT:  rd_mux = {31'd0, raw_q & ~ctrl_q.irq_mask};
        WI_RAW:   rd_mux = {31'd0, raw_q};
        WI_EOI:   rd_mux = {31'd0, raw_q};
        WI_VER:   rd_mux = VERSION;
        default:  rd_mux = '0;
      endcase
    end
  end

  logic [31:0] rdata_q;
  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = irq_q;

  assert_irq_level_R7: assert property (@(posedge clk) disable iff (rst)
    irq_out == (raw_q & ~ctrl_q.irq_mask));
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
  assert_ctrl_upper_R10: assert property (@(posedge clk) disable iff (rst)
    bus_rd && hit && idx == WI_CTRL |=> bus_rdata[31:4] == 28'd0);
endmodule

// File: tb/sec_rtc_bench.sv
`timescale 1ns/1ps
module sec_rtc_bench;
  localparam int          T   = 8;
  localparam logic [31:0] VER = 32'h0001_0200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  always #2.5 clk = ~clk;

  sec_rtc #(.TICKS_PER_SEC(T), .ADDR_W(6), .VERSION(VER)) u_sec_rtc (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // Expected state, built from the requirements
  logic [31:0] m_cnt = 0, m_load = 0, m_match = 0;
  bit m_pend = 0, m_raw = 0, m_ie = 0, m_mask = 0, m_run = 0, m_wrap = 0;
  bit set_last = 0;
  int ph = 0;

  function automatic logic [31:0] f_next();
    if (m_pend) return m_load;
    if (m_cnt == 32'hFFFF_FFFF) return m_wrap ? 32'd0 : 32'hFFFF_FFFF;
    return m_cnt + 1;
  endfunction

  always @(posedge clk) begin
    set_last = 0;
    if (!rst && m_run) begin
      ph = ph + 1;
      if (ph == T) begin
        logic [31:0] nv;
        ph = 0;
        nv = f_next();
        m_cnt = nv;
        m_pend = 0;
        if (m_ie && nv == m_match) begin
          m_raw = 1;
          set_last = 1;
        end
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [5:0] a);
    case (a[5:2])
      4'd0: return m_cnt;
      4'd1: return m_match;
      4'd2: return m_load;
      4'd3: return {28'd0, m_wrap, m_run, m_mask, m_ie};
      4'd4: return {31'd0, m_raw & ~m_mask};
      4'd5: return {31'd0, m_raw};
      4'd6: return {31'd0, m_raw};
      4'd7: return VER;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [5:0] a);
    case (a[5:2])
      4'd0: return "R2";
      4'd1: return "R10";
      4'd2: return "R4";
      4'd3: return "R10";
      4'd4: return "R7";
      4'd5: return "R6";
      4'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
    case (a[5:2])
      4'd1: m_match = d;
      4'd2: begin m_load = d; m_pend = 1; end
      4'd3: begin m_ie = d[0]; m_mask = d[1]; m_run = d[2]; m_wrap = d[3]; end
      default: ;
    endcase
    @(negedge clk);
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] got);
    logic [31:0] e;
    e = exp_rd(a);
    bus_rd = 1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 0;
    if (a[5:2] == 4'd6 && !set_last) m_raw = 0;
    @(negedge clk);
    got = bus_rdata;
    chk(req_of(a), got, e);
    chk("R7", {31'd0, irq_out}, {31'd0, m_raw & ~m_mask});
  endtask

  initial begin
    logic [31:0] v, held;
    v = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    chk("R1", bus_rdata, 32'd0);
    chk("R1", {31'd0, irq_out}, 32'd0);
    rst = 0;
    @(negedge clk);
    rd(6'h00, v); chk("R1", v, 32'd0);
    rd(6'h0C, v); chk("R1", v, 32'd0);
    rd(6'h04, v); chk("R1", v, 32'd0);

    // R9: version, unmapped, read-only writes
    rd(6'h1C, v); chk("R9", v, VER);
    rd(6'h20, v); chk("R9", v, 32'd0);
    rd(6'h3C, v); chk("R9", v, 32'd0);
    wr(6'h00, 32'h1234); wr(6'h1C, 32'hDEAD); wr(6'h14, 32'h1);
    rd(6'h00, v); chk("R9", v, 32'd0);
    rd(6'h1C, v); chk("R9", v, VER);

    // R10: control keeps 4 bits, match reads back
    wr(6'h0C, 32'hFFFF_FFF0);
    rd(6'h0C, v); chk("R10", v, 32'd0);
    wr(6'h04, 32'hA5A5_5A5A);
    rd(6'h04, v); chk("R10", v, 32'hA5A5_5A5A);

    // R2: count at one per second
    wr(6'h0C, 32'h4);
    idle(3 * T);
    rd(6'h00, v); chk("R2", v, 32'd3);
    // R11: read data holds while the counter moves
    held = v;
    idle(2 * T);
    chk("R11", bus_rdata, held);

    // R4: deferred load
    wr(6'h08, 32'd100);
    rd(6'h00, v); chk("R4", (v == 32'd100) ? 32'd1 : 32'd0, 32'd0);
    rd(6'h08, v); chk("R4", v, 32'd100);
    idle(T);
    rd(6'h00, v); chk("R4", v, exp_rd(6'h00));

    // R3: hold while stopped
    wr(6'h0C, 32'h0);
    rd(6'h00, held);
    idle(5 * T);
    rd(6'h00, v); chk("R3", v, held);
    wr(6'h0C, 32'h4);
    idle(2 * T);
    rd(6'h00, v);

    // R5: saturate, then wrap
    wr(6'h08, 32'hFFFF_FFFE);
    idle(4 * T);
    rd(6'h00, v); chk("R5", v, 32'hFFFF_FFFF);
    wr(6'h0C, 32'hC);
    idle(2 * T);
    rd(6'h00, v); chk("R5", (v < 32'd4) ? 32'd1 : 32'd0, 32'd1);

    // R6: no alarm while disabled, alarm when enabled
    wr(6'h04, m_cnt + 2);
    idle(3 * T);
    rd(6'h14, v); chk("R6", v, 32'd0);
    wr(6'h0C, 32'hD);
    wr(6'h04, m_cnt + 2);
    idle(3 * T);
    rd(6'h14, v); chk("R6", v, 32'd1);
    chk("R7", {31'd0, irq_out}, 32'd1);

    // R7: masking
    wr(6'h0C, 32'hF);
    rd(6'h10, v); chk("R7", v, 32'd0);
    chk("R7", {31'd0, irq_out}, 32'd0);
    rd(6'h14, v); chk("R6", v, 32'd1);
    wr(6'h0C, 32'hD);
    chk("R7", {31'd0, irq_out}, 32'd1);

    // R8: acknowledge
    rd(6'h18, v); chk("R8", v, 32'd1);
    rd(6'h14, v); chk("R8", v, 32'd0);
    rd(6'h18, v); chk("R8", v, 32'd0);

    // Random phase
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      case (op)
        0: wr(6'h08, ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFD : $urandom);
        1, 2: wr(6'h04, m_cnt + $urandom_range(0, 3));
        3: wr(6'h0C, {28'd0, 1'($urandom_range(0, 1)),
                      1'($urandom_range(0, 9) != 0),
                      1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0)});
        4: wr({$urandom_range(0, 15), 2'b00}, $urandom);
        5, 6: rd({$urandom_range(0, 15), 2'b00}, v);
        7: rd(6'h18, v);
        default: idle(int'($urandom_range(1, 2 * T)));
      endcase
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule